// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block translates a virtual address by reading an in-memory page table of up to four directory levels. A single-cycle `start_i` pulse captures the virtual address, the chosen root pointer and the per-level shift and width settings. The walk then descends from the top level. Each directory word either points at the next table or, when its huge marker is set, is itself the leaf. If no huge leaf appears, one last read at level 0 fetches the final page entry.

The walker issues every read through a 64-bit port with a request/ready handshake and a data-valid strobe. At the end it pulses `done_o` and presents a fault flag, the page-aligned physical address and the read/write grants. These results hold until the next walk completes. A level configured with zero width is passed over without a memory access, so one engine can serve tables of two, three or four directory levels.

Top module: `pt_walk_engine`

## Requirements
- R1: Virtual address bit 63 selects `root_hi_i` when 1 and `root_lo_i` when 0. Only the low PA_W (48) bits of the chosen root are kept.
- R2: Directory levels are visited from 4 down to 1. A level whose 6-bit width field is zero is skipped and costs no memory read. A walk that ends in a normal leaf therefore makes one read per nonzero-width directory level plus one.
- R3: For level L, the index is (VA >> base_L) masked to width_L bits. The read address is the current table pointer ORed with index*8. The per-level fields sit at bits [6L+5:6L] of `lvl_base_i` and `lvl_width_i`.
- R4: A loaded directory word is cut to its low 48 bits before use. If bit 6 (huge marker) of that word is set, the walk ends and the word is the leaf. Otherwise the word becomes the next table pointer.
- R5: A huge leaf has its level field (bits 14:13) and bit 6 cleared. If its bit 12 (huge-global) is set, bit 12 is cleared and bit 6 (global) is set. This happens before the address is formed.
- R6: When the directory levels end without a huge leaf, one more read is made using the level-0 base and width. Its full 64-bit result is the leaf.
- R7: A leaf with bit 0 (valid) clear gives `fault_o`=1 with `rd_ok_o`=0, `wr_ok_o`=0 and `pa_o`=0.
- R8: A valid leaf always grants read. It grants write only when bit 1 (dirty) is set.
- R9: For a valid leaf, `pa_o` is formed in three steps. First, add the leaf to (VA mod 2^48) masked below the base of the level that supplied the leaf. Next, clear bits 63, 62 and 61. Finally, clear bits 11:0.
- R10: At most one read is outstanding at a time. A request with ready low stays asserted with an unchanged address.
- R11: `done_o` is a one-cycle pulse. The result outputs change only together with `done_o` and stay valid until the next completion. `start_i` is ignored while a walk is in progress. After reset, `done_o`, `mem_req_o` and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| va_i | input | 64 | Virtual address to translate |
| root_lo_i | input | 64 | Root table pointer for VA[63]=0 |
| root_hi_i | input | 64 | Root table pointer for VA[63]=1 |
| lvl_base_i | input | 30 | Per-level index shift, 6 bits per level 0..4 |
| lvl_width_i | input | 30 | Per-level index width, 6 bits per level 0..4 |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 48 | Read address |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | Walk complete pulse |
| fault_o | output | 1 | Leaf not valid |
| pa_o | output | 64 | Page-aligned physical address |
| rd_ok_o | output | 1 | Read granted |
| wr_ok_o | output | 1 | Write granted |

## Verification
The bench builds the walker with its default parameters: four directory levels, 6-bit level fields, a 48-bit physical width, 64-bit words and a 4 KiB page. It programs 9-bit indices at shifts 12, 21, 30 and 39 and leaves level 4 at zero width. With a 48-bit pointer and a 64-bit output, the high bits of a directory word are visibly dropped, while bits 63:61 and bit 50 of a normal leaf reach the result path, where the clearing can be observed. The same settings make huge leaves at levels 1 and 2 reachable. Zeroing widths gives one-read and skipped-middle-level walks, and a stalling memory model exercises the handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } ptw_state_e;
endpackage

// File: rtl/ptw_lvl_pick.sv
// Highest level <= from_i with nonzero width; level 0 when none.
module ptw_lvl_pick #(
  parameter int LVL_N = 4,
  parameter int CFG_W = 6,
  localparam int LW = $clog2(LVL_N + 1),
  localparam int CW = (LVL_N + 1) * CFG_W
) (
  input  logic [CW-1:0] width_i,
  input  logic [LW-1:0] from_i,
  output logic [LW-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int l = 0; l <= LVL_N; l++) begin
      if (l <= int'(from_i) && (l == 0 || width_i[l*CFG_W +: CFG_W] != '0))
        lvl_o = LW'(l);
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 48,
  parameter int LVL_N = 4,
  parameter int CFG_W = 6,
  localparam int LW = $clog2(LVL_N + 1),
  localparam int CW = (LVL_N + 1) * CFG_W
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  tbl_i,
  input  logic [LW-1:0]    lvl_i,
  input  logic [CW-1:0]    base_cfg_i,
  input  logic [CW-1:0]    width_cfg_i,
  output logic [PA_W-1:0]  addr_o,
  output logic [CFG_W-1:0] shift_o
);
  logic [CFG_W-1:0] wd;
  logic [VA_W-1:0]  idx;

  always_comb begin
    shift_o = base_cfg_i[lvl_i*CFG_W +: CFG_W];
    wd      = width_cfg_i[lvl_i*CFG_W +: CFG_W];
    idx     = (va_i >> shift_o) & ((VA_W'(1) << wd) - VA_W'(1));
    addr_o  = tbl_i | PA_W'(idx << 3);
  end
endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int DATA_W     = 64,
  parameter int CFG_W      = 6,
  parameter int PAGE_SHIFT = 12,
  parameter int V_BIT      = 0,
  parameter int D_BIT      = 1,
  parameter int G_BIT      = 6,
  parameter int HUGE_BIT   = 6,
  parameter int HGLOB_BIT  = 12,
  parameter int LEVEL_LO   = 13,
  parameter int LEVEL_W    = 2,
  parameter int RPLV_BIT   = 63,
  parameter int NX_BIT     = 62,
  parameter int NR_BIT     = 61
) (
  input  logic [DATA_W-1:0] entry_i,
  input  logic              huge_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [CFG_W-1:0]  off_sh_i,
  output logic              fault_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] pa_o
);
  localparam logic [DATA_W-1:0] PA_MASK   = {{(DATA_W-PA_W){1'b0}}, {PA_W{1'b1}}};
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));

  logic [DATA_W-1:0] e, off, sum;

  always_comb begin
    e = entry_i;
    if (huge_i) begin
      e[LEVEL_LO +: LEVEL_W] = '0;
      e[HUGE_BIT] = 1'b0;
      if (e[HGLOB_BIT]) begin
        e[HGLOB_BIT] = 1'b0;
        e[G_BIT]     = 1'b1;
      end
    end
    off = DATA_W'(va_i) & PA_MASK & ((DATA_W'(1) << off_sh_i) - DATA_W'(1));
    sum = e + off;
    sum[RPLV_BIT] = 1'b0;
    sum[NX_BIT]   = 1'b0;
    sum[NR_BIT]   = 1'b0;
    sum = sum & PAGE_MASK;
    fault_o = ~e[V_BIT];
    rd_o    = e[V_BIT];
    wr_o    = e[V_BIT] & e[D_BIT];
    pa_o    = e[V_BIT] ? sum : '0;
  end
endmodule

// File: rtl/pt_walk_engine.sv
module pt_walk_engine
  import ptw_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int DATA_W     = 64,
  parameter int LVL_N      = 4,
  parameter int CFG_W      = 6,
  parameter int PAGE_SHIFT = 12,
  parameter int V_BIT      = 0,
  parameter int D_BIT      = 1,
  parameter int G_BIT      = 6,
  parameter int HUGE_BIT   = 6,
  parameter int HGLOB_BIT  = 12,
  parameter int LEVEL_LO   = 13,
  parameter int LEVEL_W    = 2,
  parameter int RPLV_BIT   = 63,
  parameter int NX_BIT     = 62,
  parameter int NR_BIT     = 61,
  localparam int LW = $clog2(LVL_N + 1),
  localparam int CW = (LVL_N + 1) * CFG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [DATA_W-1:0] root_lo_i,
  input  logic [DATA_W-1:0] root_hi_i,
  input  logic [CW-1:0]     lvl_base_i,
  input  logic [CW-1:0]     lvl_width_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] pa_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);
  ptw_state_e        st_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   tbl_q;
  logic [LW-1:0]     lvl_q;
  logic [CW-1:0]     cfg_b_q, cfg_w_q;
  logic [DATA_W-1:0] leaf_q;
  logic              huge_q;
  logic [CFG_W-1:0]  off_sh_q;
  logic              done_q, fault_q, rd_q, wr_q;
  logic [DATA_W-1:0] pa_q;

  logic [LW-1:0]     first_lvl, next_lvl;
  logic [PA_W-1:0]   ent_addr;
  logic [CFG_W-1:0]  cur_sh;
  logic [DATA_W-1:0] root_sel;
  logic [PA_W-1:0]   dword;
  logic              f_fault, f_rd, f_wr;
  logic [DATA_W-1:0] f_pa;

  ptw_lvl_pick #(.LVL_N(LVL_N), .CFG_W(CFG_W)) u_pick_first (
    .width_i (lvl_width_i),
    .from_i  (LW'(LVL_N)),
    .lvl_o   (first_lvl)
  );

  ptw_lvl_pick #(.LVL_N(LVL_N), .CFG_W(CFG_W)) u_pick_next (
    .width_i (cfg_w_q),
    .from_i  (lvl_q - LW'(1)),
    .lvl_o   (next_lvl)
  );

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .LVL_N(LVL_N), .CFG_W(CFG_W)) u_addr (
    .va_i        (va_q),
    .tbl_i       (tbl_q),
    .lvl_i       (lvl_q),
    .base_cfg_i  (cfg_b_q),
    .width_cfg_i (cfg_w_q),
    .addr_o      (ent_addr),
    .shift_o     (cur_sh)
  );

  ptw_leaf_fmt #(
    .VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .PAGE_SHIFT(PAGE_SHIFT),
    .V_BIT(V_BIT), .D_BIT(D_BIT), .G_BIT(G_BIT), .HUGE_BIT(HUGE_BIT), .HGLOB_BIT(HGLOB_BIT),
    .LEVEL_LO(LEVEL_LO), .LEVEL_W(LEVEL_W), .RPLV_BIT(RPLV_BIT), .NX_BIT(NX_BIT), .NR_BIT(NR_BIT)
  ) u_fmt (
    .entry_i  (leaf_q),
    .huge_i   (huge_q),
    .va_i     (va_q),
    .off_sh_i (off_sh_q),
    .fault_o  (f_fault),
    .rd_o     (f_rd),
    .wr_o     (f_wr),
    .pa_o     (f_pa)
  );

  always_comb begin
    root_sel   = va_i[VA_W-1] ? root_hi_i : root_lo_i;
    dword      = PA_W'(mem_rdata_i);
    mem_req_o  = (st_q == ST_REQ);
    mem_addr_o = ent_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      va_q     <= '0;
      tbl_q    <= '0;
      lvl_q    <= '0;
      cfg_b_q  <= '0;
      cfg_w_q  <= '0;
      leaf_q   <= '0;
      huge_q   <= 1'b0;
      off_sh_q <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      pa_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q    <= va_i;
            tbl_q   <= PA_W'(root_sel);
            cfg_b_q <= lvl_base_i;
            cfg_w_q <= lvl_width_i;
            lvl_q   <= first_lvl;
            st_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_ready_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (lvl_q == '0) begin
              leaf_q   <= mem_rdata_i;
              huge_q   <= 1'b0;
              off_sh_q <= cur_sh;
              st_q     <= ST_FIN;
            end else if (dword[HUGE_BIT]) begin
              leaf_q   <= DATA_W'(dword);
              huge_q   <= 1'b1;
              off_sh_q <= cur_sh;
              st_q     <= ST_FIN;
            end else begin
              tbl_q <= dword;
              lvl_q <= next_lvl;
              st_q  <= ST_REQ;
            end
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          fault_q <= f_fault;
          rd_q    <= f_rd;
          wr_q    <= f_wr;
          pa_q    <= f_pa;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign rd_ok_o = rd_q;
  assign wr_ok_o = wr_q;
  assign pa_o    = pa_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PA_W       = 48,
  parameter int DATA_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic [PA_W-1:0]   mem_addr_i,
  input logic              mem_ready_i,
  input logic              mem_rvalid_i,
  input logic              done_i,
  input logic              fault_i,
  input logic [DATA_W-1:0] pa_i,
  input logic              rd_ok_i,
  input logic              wr_ok_i
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (mem_req_i && mem_ready_i) pend_q <= 1'b1;
    else if (mem_rvalid_i) pend_q <= 1'b0;
  end

  a_r10_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mem_req_i);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ready_i |=> mem_req_i && $stable(mem_addr_i));

  a_r7_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && fault_i |-> !rd_ok_i && !wr_ok_i && pa_i == '0);

  a_r8_wr_needs_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && wr_ok_i |-> rd_ok_i);

  a_r9_pa_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> pa_i[PAGE_SHIFT-1:0] == '0);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r11_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(pa_i) && $stable(fault_i) && $stable(rd_ok_i) && $stable(wr_ok_i));
endmodule

bind pt_walk_engine ptw_checker #(
  .PA_W(PA_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_i    (mem_req_o),
  .mem_addr_i   (mem_addr_o),
  .mem_ready_i  (mem_ready_i),
  .mem_rvalid_i (mem_rvalid_i),
  .done_i       (done_o),
  .fault_i      (fault_o),
  .pa_i         (pa_o),
  .rd_ok_i      (rd_ok_o),
  .wr_ok_i      (wr_ok_o)
);

// File: tb/sim_pt_walk_engine.sv
`timescale 1ns/1ps
module sim_pt_walk_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] va = '0;
  logic [63:0] root_lo = '0, root_hi = '0;
  logic [29:0] lvl_base, lvl_width;
  logic        mem_req, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [47:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        done, fault, rd_ok, wr_ok;
  logic [63:0] pa;

  always #5 clk = ~clk;

  pt_walk_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va),
    .root_lo_i(root_lo), .root_hi_i(root_hi),
    .lvl_base_i(lvl_base), .lvl_width_i(lvl_width),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .pa_o(pa), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok)
  );

  logic [63:0] mem [logic [47:0]];
  int tests_run = 0, tests_failed = 0;
  int reads_cnt = 0, done_cnt = 0;
  bit stall = 1'b0, finished = 1'b0;

  typedef struct {
    logic fault; logic rd; logic wr; logic [63:0] pa; int reads; int rd0; string tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int bs(int l); return int'(lvl_base[l*6 +: 6]); endfunction
  function automatic int wd(int l); return int'(lvl_width[l*6 +: 6]); endfunction
  function automatic logic [63:0] rdmem(logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction
  // R3 address formula
  function automatic logic [47:0] ent(logic [47:0] b, logic [63:0] v, int l);
    logic [63:0] idx;
    idx = (v >> bs(l)) & ((64'd1 << wd(l)) - 64'd1);
    return b | 48'(idx << 3);
  endfunction
  task automatic put(logic [47:0] b, logic [63:0] v, int l, logic [63:0] val);
    mem[ent(b, v, l)] = val;
  endtask

  // Expected result from the requirements R1..R9
  function automatic exp_t model(logic [63:0] v, string tag);
    exp_t r; logic [47:0] b; logic [63:0] w, e, rlo, rhi; int sh; bit hit; int n;
    rlo = root_lo; rhi = root_hi;
    b = v[63] ? rhi[47:0] : rlo[47:0];
    hit = 1'b0; n = 0; sh = 0; e = '0;
    for (int l = 4; l >= 1; l--) begin
      if (!hit && wd(l) != 0) begin
        w = {16'h0, rdmem(ent(b, v, l)) & 64'h0000_FFFF_FFFF_FFFF};
        n++;
        b = w[47:0];
        if (w[6]) begin hit = 1'b1; sh = bs(l); e = w; end
      end
    end
    if (hit) begin
      e[14:13] = 2'b0; e[6] = 1'b0;
      if (e[12]) begin e[12] = 1'b0; e[6] = 1'b1; end
    end else begin
      e = rdmem(ent(b, v, 0)); n++; sh = bs(0);
    end
    r.reads = n; r.tag = tag; r.rd0 = 0;
    if (!e[0]) begin
      r.fault = 1'b1; r.rd = 1'b0; r.wr = 1'b0; r.pa = '0;
    end else begin
      r.fault = 1'b0; r.rd = 1'b1; r.wr = e[1];
      r.pa = e + ((v & 64'h0000_FFFF_FFFF_FFFF) & ((64'd1 << sh) - 64'd1));
      r.pa[63:61] = 3'b0; r.pa[11:0] = 12'h0;
    end
    return r;
  endfunction

  task automatic launch(logic [63:0] v, string tag);
    exp_t e;
    @(negedge clk);
    e = model(v, tag);
    e.rd0 = reads_cnt;
    sb.push_back(e);
    va = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic walk(logic [63:0] v, string tag);
    int d0;
    d0 = done_cnt;
    launch(v, tag);
    wait_done(d0);
  endtask

  // Memory responder: one outstanding read, optional stalls (R10)
  initial begin
    bit pend = 1'b0; int dly = 0; int cyc = 0; logic [47:0] pa_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rvalid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rvalid = 1'b1; mem_rdata = rdmem(pa_addr); pend = 1'b0;
        end else dly--;
      end
      mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (mem_req && mem_ready && !pend) begin
        pend = 1'b1; pa_addr = mem_addr; dly = stall ? 3 : 0; reads_cnt++;
      end
    end
  end

  // Scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        done_cnt++;
        if (sb.size() == 0) chk("R11", "unexpected done", 64'd1, 64'd0);
        else begin
          e = sb.pop_front();
          chk({e.tag, " R7"}, "fault", 64'(fault), 64'(e.fault));
          chk({e.tag, " R8"}, "rd_ok", 64'(rd_ok), 64'(e.rd));
          chk({e.tag, " R8"}, "wr_ok", 64'(wr_ok), 64'(e.wr));
          chk({e.tag, " R9"}, "pa", pa, e.pa);
          chk({e.tag, " R2"}, "reads", 64'(reads_cnt - e.rd0), 64'(e.reads));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    logic [63:0] held; int d0;
    lvl_base  = {6'd48, 6'd39, 6'd30, 6'd21, 6'd12};
    lvl_width = {6'd0, 6'd9, 6'd9, 6'd9, 6'd9};
    root_lo = 64'h10000;
    root_hi = 64'h1000_0000_0005_0000;
    repeat (3) @(negedge clk);
    chk("R11", "reset done", 64'(done), 64'd0);
    chk("R11", "reset req", 64'(mem_req), 64'd0);
    chk("R11", "reset fault", 64'(fault), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R6 R8: normal four-read walk, dirty
    put(48'h10000, 64'h0000_0012_3456_7ABC, 3, 64'h20000);
    put(48'h20000, 64'h0000_0012_3456_7ABC, 2, 64'h30000);
    put(48'h30000, 64'h0000_0012_3456_7ABC, 1, 64'h40000);
    put(48'h40000, 64'h0000_0012_3456_7ABC, 0, 64'h0000_0000_0ABC_D003);
    walk(64'h0000_0012_3456_7ABC, "R3 R6 normal");
    // R8: clean page, read only
    put(48'h40000, 64'h0000_0012_3456_7ABC, 0, 64'h0000_0000_0ABC_D001);
    walk(64'h0000_0012_3456_7ABC, "R8 clean");
    // R7: invalid leaf
    put(48'h40000, 64'h0000_0012_3456_7ABC, 0, 64'h0000_0000_0ABC_D002);
    walk(64'h0000_0012_3456_7ABC, "R7 invalid");
    // R9: high leaf bits 63:61 cleared, bit 50 kept
    put(48'h40000, 64'h0000_0012_3456_7ABC, 0, 64'hE004_0000_0ABC_D003);
    walk(64'h0000_0012_3456_7ABC, "R9 highbits");

    // R1: high root, bit 60 of root dropped
    put(48'h50000, 64'hFFFF_8000_1234_5000, 3, 64'h60000);
    put(48'h60000, 64'hFFFF_8000_1234_5000, 2, 64'h70000);
    put(48'h70000, 64'hFFFF_8000_1234_5000, 1, 64'h80000);
    put(48'h80000, 64'hFFFF_8000_1234_5000, 0, 64'h0000_0000_0DEF_0003);
    walk(64'hFFFF_8000_1234_5000, "R1 high root");

    // R4 R5: huge leaf at level 1 with level field and huge-global set
    put(48'h10000, 64'h0000_0000_4567_89AB, 3, 64'h21000);
    put(48'h21000, 64'h0000_0000_4567_89AB, 2, 64'h31000);
    put(48'h31000, 64'h0000_0000_4567_89AB, 1, 64'h0000_0000_8000_7043);
    walk(64'h0000_0000_4567_89AB, "R5 huge L1");
    // R4: huge leaf at level 2, bit 50 of directory word dropped
    put(48'h10000, 64'h0000_0001_2345_6789, 3, 64'h22000);
    put(48'h22000, 64'h0000_0001_2345_6789, 2, 64'h0004_0000_C000_0041);
    walk(64'h0000_0001_2345_6789, "R4 huge L2");

    // R2: only level 0 active, one read
    lvl_width = {6'd0, 6'd0, 6'd0, 6'd0, 6'd9};
    put(48'h10000, 64'h0000_0000_0000_5123, 0, 64'h0000_0000_0111_1003);
    walk(64'h0000_0000_0000_5123, "R2 single");
    // R2: middle level 2 skipped
    lvl_width = {6'd0, 6'd9, 6'd0, 6'd9, 6'd9};
    put(48'h10000, 64'h0000_0012_3456_7ABC, 3, 64'h23000);
    put(48'h23000, 64'h0000_0012_3456_7ABC, 1, 64'h33000);
    put(48'h33000, 64'h0000_0012_3456_7ABC, 0, 64'h0000_0000_0222_2003);
    walk(64'h0000_0012_3456_7ABC, "R2 skip");

    // R10: stalled ready and delayed data
    lvl_width = {6'd0, 6'd9, 6'd9, 6'd9, 6'd9};
    put(48'h10000, 64'h0000_0012_3456_7ABC, 3, 64'h20000);
    put(48'h40000, 64'h0000_0012_3456_7ABC, 0, 64'h0000_0000_0ABC_D003);
    stall = 1'b1;
    walk(64'h0000_0012_3456_7ABC, "R10 stall");
    stall = 1'b0;

    // R11: start while busy is ignored
    d0 = done_cnt;
    launch(64'h0000_0012_3456_7ABC, "R11 busy");
    @(negedge clk);
    va = 64'hFFFF_8000_1234_5000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(d0);
    repeat (30) @(negedge clk);
    chk("R11", "done count", 64'(done_cnt - d0), 64'd1);
    // R11: result held after completion
    held = pa;
    repeat (6) @(negedge clk);
    chk("R11", "pa held", pa, held);
    chk("R11", "done low", 64'(done), 64'd0);
    chk("R11", "scoreboard empty", 64'(sb.size()), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule